// File: doc/BRIEF.md
# ATC Invalidation Command Generator

This block converts one request to drop cached translations for an I/O virtual address range into the command stream a translation unit's command queue expects. A request carries a substream identifier, a byte start address, a byte length, a flag saying whether the owning master has address translation services turned on, and a list of up to eight stream identifiers. The block widens the range to a single naturally aligned power-of-two run of 4 KiB pages. It issues one 128-bit invalidation command per stream identifier, then one synchronisation command.

Commands leave on a valid/ready channel. After the synchronisation command is taken, the block waits for a completion acknowledge. If the acknowledge does not arrive within a parameterised number of cycles, the block reports the completion-timeout error code and returns to idle. The queue storage, the link transport and the stream table lookup sit outside the block.

Top module: `atcinv_cmdgen`

## Requirements
- R1: Page numbers use a 4 KiB granule: the first page is `req_addr >> 12` and the last page is `(req_addr + req_len - 1) >> 12`, computed modulo 2^64.
- R2: For a nonzero length, the span exponent is the 1-based index of the highest set bit of (first page XOR last page), or 0 when the two pages match. The base page is the first page with its low span-exponent bits cleared. Command word 1 is `cmd_data[127:64]`. In it, bits 5:0 hold the exponent, bits 63:12 hold the base page, and bits 11:6 are zero.
- R3: A zero length requests a full invalidation. The exponent field holds 52 and the base page field holds 0.
- R4: Command word 0 is `cmd_data[63:0]`. It holds opcode 0x40 in bits 7:0, zero in bit 9, the substream-valid flag in bit 11, the substream identifier in bits 31:12 and the stream identifier in bits 63:32. Bits 8 and 10 are zero.
- R5: The substream-valid flag is 1 exactly when the substream identifier is nonzero.
- R6: With translation services enabled and a count N from 1 to 8, the block emits N invalidation commands. Stream identifier i comes from `req_sids[32*i +: 32]`, and the commands go out in order i = 0 to N-1. They are followed by exactly one synchronisation command, which is all zero except opcode 0x46 in bits 7:0.
- R7: With translation services disabled, an accepted request produces no command. `done` is high for one cycle, in the cycle after acceptance.
- R8: With translation services enabled and a count of 0, only the synchronisation command is emitted.
- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_data` does not change.
- R10: `req_ready` is high only when the block is idle, and a request is taken on `req_valid && req_ready`. `done` is a one-cycle pulse in the cycle after the synchronisation command is taken.
- R11: Command error codes are 0 (none), 1 (illegal command), 2 (fetch abort) and 3 (invalidation completion timeout). A `cmpl_ack` pulse after the synchronisation command returns the block to idle with `err_code` 0. Suppose no acknowledge arrives within TMO_CYCLES cycles of the synchronisation handshake. Then `err_code` becomes 3 at that point and the block returns to idle. `err_code` goes back to 0 when the next request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_ssid | input | 20 | Substream identifier |
| req_addr | input | 64 | Start byte address |
| req_len | input | 64 | Length in bytes, 0 = everything |
| req_ats_en | input | 1 | Master has translation services enabled |
| req_sid_cnt | input | 4 | Number of stream identifiers (0 to 8) |
| req_sids | input | 256 | Packed stream identifier list, entry i at bits 32*i+31:32*i |
| cmd_valid | output | 1 | Command on `cmd_data` |
| cmd_ready | input | 1 | Queue takes the command |
| cmd_data | output | 128 | Command, word 0 in bits 63:0, word 1 in bits 127:64 |
| cmpl_ack | input | 1 | Completion of the synchronisation observed |
| done | output | 1 | One-cycle pulse at end of issue |
| err_code | output | 2 | Command error code, 0 or 3 |

## Verification
The hardest case to reach is the completion timeout. The block only starts counting after the synchronisation handshake, so the bench has to finish a whole issue sequence and then hold `cmpl_ack` low. It checks `err_code` and `req_ready` on the cycle just before the limit and on the limit cycle itself, then takes a new request to show the code clears. The span arithmetic is driven with ranges whose end pages differ in a high bit from an unaligned start, which forces the base well below the start. Back-pressure is applied by holding `cmd_ready` low over several cycles on every command of one sequence.

// File: rtl/atcinv_pkg.sv
package atcinv_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int WORD_W     = 64;
  localparam int CMD_W      = 2 * WORD_W;
  localparam int SID_W      = 32;
  localparam int SSID_W     = 20;
  localparam int SIZE_W     = 6;

  localparam logic [7:0]        OP_ATC_INV = 8'h40;
  localparam logic [7:0]        OP_SYNC    = 8'h46;
  localparam logic [SIZE_W-1:0] SIZE_ALL   = 6'd52;

  localparam logic [1:0] ERR_NONE    = 2'd0;
  localparam logic [1:0] ERR_ILLEGAL = 2'd1;
  localparam logic [1:0] ERR_ABORT   = 2'd2;
  localparam logic [1:0] ERR_ATC_TMO = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INV  = 2'd1,
    ST_SYNC = 2'd2,
    ST_WAIT = 2'd3
  } seq_st_t;
endpackage

// File: rtl/atcinv_span.sv
module atcinv_span
  import atcinv_pkg::*;
#(
  parameter int ADDR_W = 64,
  localparam int PG_W  = ADDR_W - PAGE_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] len,
  output logic [SIZE_W-1:0] size,
  output logic [PG_W-1:0]   base_pg
);
  logic [ADDR_W-1:0] last_b;
  logic [ADDR_W-1:0] diff_b;
  logic [ADDR_W-1:0] base_b;
  logic [SIZE_W-1:0] lg;

  always_comb begin
    last_b = addr + len - {{(ADDR_W-1){1'b0}}, 1'b1};
    diff_b = addr ^ last_b;
    lg     = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i >= PAGE_SHIFT && diff_b[i]) lg = SIZE_W'(i + 1 - PAGE_SHIFT);
    end
    for (int i = 0; i < ADDR_W; i++) begin
      base_b[i] = (i < PAGE_SHIFT + int'(lg)) ? 1'b0 : addr[i];
    end
    if (len == '0) begin
      size    = SIZE_ALL;
      base_pg = '0;
    end else begin
      size    = lg;
      base_pg = PG_W'(base_b >> PAGE_SHIFT);
    end
  end
endmodule

// File: rtl/atcinv_pack.sv
module atcinv_pack
  import atcinv_pkg::*;
#(
  parameter int PG_W = 52
) (
  input  logic              is_sync,
  input  logic [SSID_W-1:0] ssid,
  input  logic [SID_W-1:0]  sid,
  input  logic [SIZE_W-1:0] size,
  input  logic [PG_W-1:0]   base_pg,
  output logic [CMD_W-1:0]  cmd
);
  logic [WORD_W-1:0] w0;
  logic [WORD_W-1:0] w1;

  always_comb begin
    w0 = '0;
    w1 = '0;
    if (is_sync) begin
      w0[7:0] = OP_SYNC;
    end else begin
      w0[7:0]                 = OP_ATC_INV;
      w0[9]                   = 1'b0;
      w0[11]                  = |ssid;
      w0[12 +: SSID_W]        = ssid;
      w0[32 +: SID_W]         = sid;
      w1[SIZE_W-1:0]          = size;
      w1[PAGE_SHIFT +: PG_W]  = base_pg;
    end
    cmd = {w1, w0};
  end
endmodule

// File: rtl/atcinv_ctrl.sv
module atcinv_ctrl
  import atcinv_pkg::*;
#(
  parameter int MAX_SIDS   = 8,
  parameter int TMO_CYCLES = 1024,
  localparam int CNT_W = $clog2(MAX_SIDS + 1),
  localparam int IDX_W = (MAX_SIDS > 1) ? $clog2(MAX_SIDS) : 1,
  localparam int TMR_W = $clog2(TMO_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_ats_en,
  input  logic [CNT_W-1:0] req_cnt,
  input  logic             cmd_ready,
  input  logic             cmpl_ack,
  output logic             req_ready,
  output logic             accept,
  output logic             cmd_valid,
  output logic             is_sync,
  output logic [IDX_W-1:0] idx,
  output logic             done,
  output logic [1:0]       err_code
);
  seq_st_t          st_q, st_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [TMR_W-1:0] tmr_q, tmr_n;
  logic             done_q, done_n;
  logic [1:0]       err_q, err_n;
  logic [CNT_W-1:0] cnt_clamp;
  logic [CNT_W-1:0] idx_next;
  logic             hs;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cmd_valid = (st_q == ST_INV) || (st_q == ST_SYNC);
  assign is_sync   = (st_q == ST_SYNC);
  assign hs        = cmd_valid && cmd_ready;
  assign cnt_clamp = (req_cnt > CNT_W'(MAX_SIDS)) ? CNT_W'(MAX_SIDS) : req_cnt;
  assign idx_next  = CNT_W'(idx_q) + CNT_W'(1);

  always_comb begin
    st_n   = st_q;
    idx_n  = idx_q;
    cnt_n  = cnt_q;
    tmr_n  = tmr_q;
    err_n  = err_q;
    done_n = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          err_n  = ERR_NONE;
          idx_n  = '0;
          cnt_n  = cnt_clamp;
          done_n = !req_ats_en;
          if (req_ats_en) st_n = (cnt_clamp == '0) ? ST_SYNC : ST_INV;
        end
      end
      ST_INV: begin
        if (hs) begin
          if (idx_next == cnt_q) st_n  = ST_SYNC;
          else                   idx_n = idx_q + IDX_W'(1);
        end
      end
      ST_SYNC: begin
        if (hs) begin
          st_n   = ST_WAIT;
          tmr_n  = '0;
          done_n = 1'b1;
        end
      end
      ST_WAIT: begin
        if (cmpl_ack) begin
          st_n = ST_IDLE;
        end else if (tmr_q == TMR_W'(TMO_CYCLES - 1)) begin
          st_n  = ST_IDLE;
          err_n = ERR_ATC_TMO;
        end else begin
          tmr_n = tmr_q + TMR_W'(1);
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      cnt_q  <= '0;
      tmr_q  <= '0;
      done_q <= 1'b0;
      err_q  <= ERR_NONE;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      cnt_q  <= cnt_n;
      tmr_q  <= tmr_n;
      done_q <= done_n;
      err_q  <= err_n;
    end
  end

  assign idx      = idx_q;
  assign done     = done_q;
  assign err_code = err_q;
endmodule

// File: rtl/atcinv_cmdgen.sv
module atcinv_cmdgen
  import atcinv_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int MAX_SIDS   = 8,
  parameter int TMO_CYCLES = 1024,
  localparam int PG_W  = ADDR_W - PAGE_SHIFT,
  localparam int CNT_W = $clog2(MAX_SIDS + 1),
  localparam int IDX_W = (MAX_SIDS > 1) ? $clog2(MAX_SIDS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [SSID_W-1:0]         req_ssid,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [ADDR_W-1:0]         req_len,
  input  logic                      req_ats_en,
  input  logic [CNT_W-1:0]          req_sid_cnt,
  input  logic [MAX_SIDS*SID_W-1:0] req_sids,
  output logic                      cmd_valid,
  input  logic                      cmd_ready,
  output logic [CMD_W-1:0]          cmd_data,
  input  logic                      cmpl_ack,
  output logic                      done,
  output logic [1:0]                err_code
);
  logic                               rst_s1, rst_s2;
  logic                               accept;
  logic                               is_sync;
  logic [IDX_W-1:0]                   idx;
  logic [SIZE_W-1:0]                  size_d, size_q;
  logic [PG_W-1:0]                    base_d, base_q;
  logic [SSID_W-1:0]                  ssid_q;
  logic [MAX_SIDS-1:0][SID_W-1:0]     sids_d, sids_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  assign sids_d = req_sids;

  atcinv_span #(.ADDR_W(ADDR_W)) u_span (
    .addr    (req_addr),
    .len     (req_len),
    .size    (size_d),
    .base_pg (base_d)
  );

  atcinv_ctrl #(.MAX_SIDS(MAX_SIDS), .TMO_CYCLES(TMO_CYCLES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s2),
    .req_valid  (req_valid),
    .req_ats_en (req_ats_en),
    .req_cnt    (req_sid_cnt),
    .cmd_ready  (cmd_ready),
    .cmpl_ack   (cmpl_ack),
    .req_ready  (req_ready),
    .accept     (accept),
    .cmd_valid  (cmd_valid),
    .is_sync    (is_sync),
    .idx        (idx),
    .done       (done),
    .err_code   (err_code)
  );

  // request capture, enabled by acceptance
  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      size_q <= '0;
      base_q <= '0;
      ssid_q <= '0;
      sids_q <= '0;
    end else if (accept) begin
      size_q <= size_d;
      base_q <= base_d;
      ssid_q <= req_ssid;
      sids_q <= sids_d;
    end
  end

  atcinv_pack #(.PG_W(PG_W)) u_pack (
    .is_sync (is_sync),
    .ssid    (ssid_q),
    .sid     (sids_q[idx]),
    .size    (size_q),
    .base_pg (base_q),
    .cmd     (cmd_data)
  );
endmodule

// File: rtl/atcinv_cmdgen_chk.sv
module atcinv_cmdgen_chk
  import atcinv_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_ats_en,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [CMD_W-1:0] cmd_data,
  input logic             done,
  input logic [1:0]       err_code
);
  // R9: command held under back-pressure
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

  // R10: no command while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);

  // R10, R7: done follows a sync handshake or a disabled-master acceptance
  p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cmd_valid && cmd_ready && cmd_data[7:0] == OP_SYNC)
                 || $past(req_valid && req_ready && !req_ats_en));

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: address low bits above the size field stay zero
  p_addr_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_data[7:0] == OP_ATC_INV |-> cmd_data[75:70] == 6'd0);

  // R5: substream-valid tracks a nonzero substream identifier
  p_ssv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_data[7:0] == OP_ATC_INV |-> cmd_data[11] == (cmd_data[31:12] != 20'd0));

  // R11: only the none and timeout codes appear, and timeout implies idle
  p_err_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code == ERR_ATC_TMO) |-> req_ready);

  p_err_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_code == ERR_NONE || err_code == ERR_ATC_TMO);
endmodule

bind atcinv_cmdgen atcinv_cmdgen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_ats_en (req_ats_en),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_data   (cmd_data),
  .done       (done),
  .err_code   (err_code)
);

// File: tb/sim_atcinv_cmdgen.sv
`timescale 1ns/1ps
module sim_atcinv_cmdgen;
  localparam int TMO = 20;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic [19:0]  req_ssid;
  logic [63:0]  req_addr;
  logic [63:0]  req_len;
  logic         req_ats_en;
  logic [3:0]   req_sid_cnt;
  logic [255:0] req_sids;
  logic         cmd_valid;
  logic         cmd_ready;
  logic [127:0] cmd_data;
  logic         cmpl_ack;
  logic         done;
  logic [1:0]   err_code;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  atcinv_cmdgen #(.ADDR_W(64), .MAX_SIDS(8), .TMO_CYCLES(TMO)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ssid(req_ssid),
    .req_addr(req_addr), .req_len(req_len), .req_ats_en(req_ats_en),
    .req_sid_cnt(req_sid_cnt), .req_sids(req_sids),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmpl_ack(cmpl_ack), .done(done), .err_code(err_code)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sid_of(input int seed, input int i);
    return 32'hA000_0000 + 32'(seed * 16 + i);
  endfunction

  // expected invalidation command from R1..R5
  function automatic logic [127:0] exp_inv(input logic [19:0] ssid, input logic [63:0] addr,
                                           input logic [63:0] len, input logic [31:0] sid);
    logic [63:0] w0, w1, first_pg, last_pg, x, base;
    int lg;
    w0 = 64'h40;
    w0[11] = (ssid != 0);
    w0[31:12] = ssid;
    w0[63:32] = sid;
    if (len == 0) begin
      w1 = 64'd52;
    end else begin
      first_pg = addr >> 12;
      last_pg  = (addr + len - 64'd1) >> 12;
      x  = first_pg ^ last_pg;
      lg = 0;
      for (int b = 63; b >= 0; b--) if (x[b] && lg == 0) lg = b + 1;
      base = (first_pg >> lg) << lg;
      w1 = (base << 12) | 64'(lg);
    end
    return {w1, w0};
  endfunction

  // drive one request, collect its commands, optionally acknowledge
  task automatic run_req(input string tag, input logic [19:0] ssid, input logic [63:0] addr,
                         input logic [63:0] len, input bit ats, input int cnt,
                         input int seed, input bit stall, input bit ack);
    logic [127:0] cur, exp;
    int n;
    @(negedge clk);
    chk(req_ready === 1'b1, {tag, " R10 ready before request"}, 128'(req_ready), 128'd1);
    req_ssid = ssid; req_addr = addr; req_len = len; req_ats_en = ats;
    req_sid_cnt = 4'(cnt);
    for (int i = 0; i < 8; i++) req_sids[32*i +: 32] = sid_of(seed, i);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err_code == 2'd0, {tag, " R11 error cleared on accept"}, 128'(err_code), 128'd0);
    if (!ats) begin
      chk(done === 1'b1, {tag, " R7 done after accept"}, 128'(done), 128'd1);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(cmd_valid === 1'b0, {tag, " R7 no command"}, 128'(cmd_valid), 128'd0);
      end
      chk(req_ready === 1'b1, {tag, " R7 idle"}, 128'(req_ready), 128'd1);
      return;
    end
    n = cnt + 1;
    for (int k = 0; k < n; k++) begin
      for (int w = 0; w < 20 && !cmd_valid; w++) @(negedge clk);
      cur = cmd_data;
      if (stall) begin
        repeat (2) @(negedge clk);
        chk(cmd_valid === 1'b1 && cmd_data === cur, {tag, " R9 held under stall"}, cmd_data, cur);
      end
      exp = (k == cnt) ? 128'h46 : exp_inv(ssid, addr, len, sid_of(seed, k));
      chk(cur === exp, (k == cnt) ? {tag, " R6 sync command"} : {tag, " R6 R2 R4 invalidation"}, cur, exp);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      if (k == cnt)
        chk(done === 1'b1, {tag, " R10 done after sync"}, 128'(done), 128'd1);
      else
        chk(done === 1'b0, {tag, " R10 no early done"}, 128'(done), 128'd0);
    end
    if (ack) begin
      cmpl_ack = 1'b1;
      @(negedge clk);
      cmpl_ack = 1'b0;
      chk(req_ready === 1'b1 && err_code == 2'd0 && done === 1'b0,
          {tag, " R11 ack returns idle"}, {req_ready, done, err_code}, 128'b1000);
    end
  endtask

  task automatic t_reset();
    chk(req_ready === 1'b1 && cmd_valid === 1'b0 && done === 1'b0 && err_code == 2'd0,
        "reset R10 idle state", {req_ready, cmd_valid, done, err_code}, 128'b10000);
  endtask

  task automatic t_aligned();   // pages 8..11, R1 R2
    run_req("aligned", 20'd0, 64'h8000, 64'h4000, 1'b1, 2, 1, 1'b0, 1'b1);
  endtask

  task automatic t_widened();   // pages 7..10 widen to 0..15, R2 R5, with back-pressure R9
    run_req("widened", 20'd5, 64'h7000, 64'h4000, 1'b1, 3, 2, 1'b1, 1'b1);
  endtask

  task automatic t_single_page(); // R1 unaligned byte range inside one page
    run_req("onepage", 20'hFFFFF, 64'h12345, 64'd1, 1'b1, 1, 3, 1'b0, 1'b1);
  endtask

  task automatic t_all();       // R3 zero length
    run_req("all", 20'd7, 64'hDEAD_B000, 64'd0, 1'b1, 1, 4, 1'b0, 1'b1);
  endtask

  task automatic t_no_ats();    // R7
    run_req("noats", 20'd1, 64'h4000, 64'h1000, 1'b0, 4, 5, 1'b0, 1'b0);
  endtask

  task automatic t_zero_cnt();  // R8
    run_req("zerocnt", 20'd0, 64'h4000, 64'h1000, 1'b1, 0, 6, 1'b0, 1'b1);
  endtask

  task automatic t_full_list(); // R6 eight identifiers, high addresses crossing a large boundary
    run_req("eight", 20'h00ABC, 64'h0000_7FFF_FFFF_F800, 64'h1000, 1'b1, 8, 7, 1'b0, 1'b1);
  endtask

  task automatic t_timeout();   // R11
    run_req("tmo", 20'd2, 64'h9000, 64'h2000, 1'b1, 1, 8, 1'b0, 1'b0);
    repeat (TMO - 1) @(negedge clk);
    chk(err_code == 2'd0 && req_ready === 1'b0, "tmo R11 not yet expired",
        {req_ready, err_code}, 128'b000);
    @(negedge clk);
    chk(err_code == 2'd3 && req_ready === 1'b1, "tmo R11 expired code 3",
        {req_ready, err_code}, 128'b111);
    run_req("after_tmo", 20'd0, 64'h1000, 64'h1000, 1'b1, 1, 9, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", n_chk, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_ssid = '0; req_addr = '0; req_len = '0;
    req_ats_en = 1'b0; req_sid_cnt = '0; req_sids = '0; cmd_ready = 1'b0; cmpl_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_aligned();
    t_widened();
    t_single_page();
    t_all();
    t_no_ats();
    t_zero_cnt();
    t_full_list();
    t_timeout();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule